// File: doc/BRIEF.md
# Burst Read Initial Latency Controller

This block is the synchronous burst-read front end of a flash-style memory slave. A burst begins when the active-low address-valid strobe is low at a rising clock edge. That edge captures the start address and the latency code, and it counts as clock one. After a first-word delay of three, four or five clocks, chosen by the code, the block puts one 32-bit word per clock on the data bus for a fixed number of words. It then goes quiet until the next strobe.

The array behind the controller is a combinational lookup indexed by a linear address counter. All data is launched on rising edges. A new strobe at any point in a burst drops the current burst and starts the latency count again from the new address.

The FSM has three states:

- `ST_IDLE` waits for a strobe.
- `ST_WAIT` counts down the initial latency.
- `ST_DATA` streams words.

Its transitions are:

- strobe → `ST_WAIT` from any state (start or abort).
- `ST_WAIT` → `ST_DATA` when the countdown reaches zero, which emits the first word.
- `ST_DATA` → `ST_DATA` while words remain.
- `ST_DATA` → `ST_IDLE` after the last word.

Top module: `burst_lat_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dq_valid` is 0 and `dq_out` is all zeros.
- R2: A burst starts only at a rising edge with `adv_n` low, and that edge samples `addr_in` and `lat_code`. Changes to `addr_in` or `lat_code` while `adv_n` is high have no effect on the output. If `adv_n` stays low on several edges, each of those edges restarts the burst.
- R3: With latency code 1, word D0 is on the bus after the 3rd rising edge, where the start edge is the 1st.
- R4: With latency code 2, D0 appears after the 4th rising edge.
- R5: With latency code 3, D0 appears after the 5th rising edge.
- R6: Any latency code other than 1, 2 or 3 (for example 0, 4, 7 or 15) behaves as a five-clock delay.
- R7: With latency L and start address A, word Dk is on the bus after edge L+k for k = 0 to BURST_LEN-1. Its value is the array word at address A+k. The array word at address a is {a[15:0] XOR 16'hC3A5, a[15:0]}. After BURST_LEN words, output stops.
- R8: `dq_valid` is high on exactly the cycles that carry burst data, and `dq_out` is all zeros on every other cycle.
- R9: An `adv_n` assertion during the wait or data phase aborts the burst. `dq_valid` is low after that edge, and the new burst follows R3 to R7 from the new address and code.
- R10: The burst address counter steps by one word per data clock and wraps modulo 2^AW (with AW=16, 16'hFFFF is followed by 16'h0000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling and data launch on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_n | input | 1 | Active-low address-valid strobe that starts a burst |
| addr_in | input | AW | Start word address, sampled with the strobe |
| lat_code | input | 4 | Initial latency code, sampled with the strobe |
| dq_out | output | 32 | Burst data word, zero when not valid |
| dq_valid | output | 1 | High on cycles carrying burst data |

## Verification
The timing tests start bursts with latency codes 1, 2 and 3, which separate the three delays by the exact edge of the first word. Codes 0, 4, 7 and 15 show whether out-of-range values fall back to five clocks rather than to some other setting. Restarts are tried in the middle of the data phase, in the middle of the wait phase, and with the strobe held low on two edges, which separates a true restart from a burst that continues or merges. A start address of 16'hFFFE exposes a counter that fails to wrap. Random address and code values are driven while the strobe is high, which would show any sampling outside the start edge.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2
    } bst_t;

    localparam int DATA_W = 32;

    // Array content model: low half is the address, high half a scrambled copy.
    function automatic logic [DATA_W-1:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

endpackage

// File: rtl/burst_lat_decode.sv
module burst_lat_decode #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  wait_init
);
    // Countdown preload = latency - 2 (start edge and emitting edge excluded).
    always_comb begin
        unique case (code)
            CODE_W'(1): wait_init = CNT_W'(1);  // three clocks
            CODE_W'(2): wait_init = CNT_W'(2);  // four clocks
            default:    wait_init = CNT_W'(3);  // code 3 and out of range: five clocks
        endcase
    end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_addr;
        else if (inc)  addr <= addr + AW'(1);
    end

    assert_inc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr == $past(addr) + AW'(1)));

    assert_load_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(load_addr)));
endmodule

// File: rtl/burst_mem_model.sv
module burst_mem_model #(
    parameter int AW = 16
) (
    input  logic [AW-1:0]                   addr,
    output logic [burst_lat_pkg::DATA_W-1:0] word
);
    always_comb word = burst_lat_pkg::mem_word(32'(addr));
endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl #(
    parameter int AW        = 16,
    parameter int CODE_W    = 4,
    parameter int BURST_LEN = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             adv_n,
    input  logic [AW-1:0]                    addr_in,
    input  logic [CODE_W-1:0]                lat_code,
    output logic [burst_lat_pkg::DATA_W-1:0] dq_out,
    output logic                             dq_valid
);
    import burst_lat_pkg::*;

    localparam int CNT_W  = 3;
    localparam int BEAT_W = $clog2(BURST_LEN + 1);

    bst_t              state, state_d;
    logic [CNT_W-1:0]  wcnt, wcnt_d, wait_init;
    logic [BEAT_W-1:0] beat, beat_d;
    logic              start, emit;
    logic [AW-1:0]     cur_addr;
    logic [DATA_W-1:0] cur_word;

    assign start = !adv_n;

    burst_lat_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .code      (lat_code),
        .wait_init (wait_init)
    );

    burst_addr_ctr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_addr (addr_in),
        .inc       (emit),
        .addr      (cur_addr)
    );

    burst_mem_model #(.AW(AW)) u_mem (
        .addr (cur_addr),
        .word (cur_word)
    );

    // Next-state logic; a strobe takes priority in every state (start/abort).
    always_comb begin
        state_d = state;
        wcnt_d  = wcnt;
        beat_d  = beat;
        emit    = 1'b0;
        if (start) begin
            state_d = ST_WAIT;
            wcnt_d  = wait_init;
            beat_d  = '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_WAIT: begin
                    if (wcnt == '0) begin
                        emit    = 1'b1;
                        beat_d  = BEAT_W'(1);
                        state_d = ST_DATA;
                    end else begin
                        wcnt_d = wcnt - CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (beat == BEAT_W'(BURST_LEN)) begin
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end else begin
                        emit   = 1'b1;
                        beat_d = beat + BEAT_W'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            beat  <= '0;
        end else begin
            state <= state_d;
            wcnt  <= wcnt_d;
            beat  <= beat_d;
        end
    end

    // Output register: data launched on the rising edge, zero when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_out   <= '0;
            dq_valid <= 1'b0;
        end else begin
            dq_valid <= emit;
            dq_out   <= emit ? cur_word : '0;
        end
    end

    assert_start_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_WAIT));

    assert_abort_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> !dq_valid);

    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_out == '0));

    assert_valid_in_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (state == ST_DATA));

    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (wcnt <= CNT_W'(3)));

    assert_beat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat <= BEAT_W'(BURST_LEN));
endmodule

// File: tb/tb_burst_lat_ctrl.sv
module tb_burst_lat_ctrl;
    localparam int AW = 16;
    localparam int BL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [3:0]    lat_code = '0;
    logic [31:0]   dq_out;
    logic          dq_valid;

    always #5 clk = ~clk;

    burst_lat_ctrl #(.AW(AW), .CODE_W(4), .BURST_LEN(BL)) dut (
        .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .addr_in(addr_in),
        .lat_code(lat_code), .dq_out(dq_out), .dq_valid(dq_valid)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: edges since the last start, latency, base address
    bit m_have = 1'b0;
    int m_e    = 0;
    int m_lat  = 5;
    int m_base = 0;

    function automatic int lat_of(input int c);
        if (c == 1) return 3;
        if (c == 2) return 4;
        return 5;
    endfunction

    function automatic logic [31:0] word_of(input int a);
        logic [15:0] lo;
        lo = a[15:0];
        return {lo ^ 16'hC3A5, lo};
    endfunction

    // Compares both outputs against the model every cycle (R8 is checked on every call)
    task automatic chk_now(input string req);
        bit          ev;
        logic [31:0] ed;
        ev = m_have && (m_e >= m_lat) && (m_e - m_lat < BL);
        ed = ev ? word_of((m_base + m_e - m_lat) & 16'hFFFF) : 32'h0;
        checks++;
        if (dq_valid !== ev || dq_out !== ed) begin
            fails++;
            $display("FAIL %s/R8 edge=%0d valid=%0b data=%h expected valid=%0b data=%h",
                     req, m_e, dq_valid, dq_out, ev, ed);
        end
    endtask

    task automatic step(input bit a, input int ad, input int code, input string req);
        adv_n    = a;
        addr_in  = ad[AW-1:0];
        lat_code = code[3:0];
        @(posedge clk);
        if (!a) begin
            m_have = 1'b1; m_e = 1; m_lat = lat_of(code); m_base = ad & 16'hFFFF;
        end else if (m_have) begin
            m_e++;
        end
        @(negedge clk);
        chk_now(req);
    endtask

    // Idle cycles with random address/code noise while the strobe is high (R2)
    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, int'($urandom_range(0, 65535)),
                                         int'($urandom_range(0, 15)), req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, checked during and right after reset
        repeat (3) @(negedge clk);
        chk_now("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_now("R1");

        step(0, 'h0100, 1, "R3"); idle(12, "R3");
        step(0, 'h0200, 2, "R4"); idle(13, "R4");
        step(0, 'h0300, 3, "R5"); idle(14, "R5");
        foreach (codes_q[i]) begin
            step(0, 'h2000 + i * 'h40, codes_q[i], "R6");
            idle(14, "R6");
        end
        step(0, 'h1000, 2, "R7"); idle(14, "R7");
        // R10: wrap across the top of the address space
        step(0, 'hFFFE, 1, "R10"); idle(12, "R10");
        // R9: abort in the data phase, then in the wait phase
        step(0, 'h0400, 1, "R9"); idle(4, "R9");
        step(0, 'h0500, 2, "R9"); idle(14, "R9");
        step(0, 'h0600, 3, "R9"); idle(1, "R9");
        step(0, 'h0700, 1, "R9"); idle(12, "R9");
        // R2: strobe held low on two edges restarts on the second
        step(0, 'h0800, 1, "R2"); step(0, 'h0900, 1, "R2"); idle(12, "R2");
        idle(6, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    int codes_q[4] = '{0, 4, 7, 15};
endmodule